// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial transceiver for a host bus. A single-cycle enable, `tick16`, pulses sixteen times per bit period. Every bit cell on both the transmit and the receive side lasts sixteen of these pulses. Bit-rate generation, line drivers and modem signals live outside the block.

The transmitter has a one-byte holding buffer in front of its shift register. A host write strobe puts a byte into the holding buffer. If the shifter is idle, the byte moves into the shifter on the next clock, and the buffer-empty flag rises again straight away. The host can therefore queue a second byte while the first one is still on the line. The transmit state machine has five states:
- `TX_IDLE`: the line is high. The machine leaves for `TX_START` whenever the holding buffer is full.
- `TX_START` → `TX_DATA`: the start cell.
- `TX_DATA` → `TX_PAR` or `TX_STOP`: the data cells, LSB first.
- `TX_PAR` → `TX_STOP`: the parity cell.
- `TX_STOP`: one or two stop cells. At the end, it goes to `TX_START` if another byte is queued, and to `TX_IDLE` if not.

The receive state machine has five states:
- `RX_HUNT` → `RX_START`: a low sample on the synchronised line.
- `RX_START`: the start bit is checked half a bit later. If the line is high again, the machine goes back to `RX_HUNT`. If it is still low, it goes on to `RX_DATA`.
- `RX_DATA` → `RX_PAR` or `RX_STOP`: the data cells.
- `RX_PAR` → `RX_STOP`: the parity cell.
- `RX_STOP` → `RX_HUNT`: the stop cell. The character is delivered only if the stop sample is high.

The receive buffer holds the last character together with its parity-error and overrun flags. A host strobe clears the buffer flags. Three static inputs select the character format. Parity on gives 7-bit characters and parity off gives 8-bit characters. The other two inputs select even or odd parity, and one or two stop bits.

Top module: `sio_xcvr`

## Requirements
- R1: Each start, data, parity and stop cell driven on `ser_out` lasts 16 `tick16` pulses. The receiver samples each cell at its 16th tick after the point where it verified the start bit, which puts the sample near the middle of the cell.
- R2: After reset, `tx_empty` is 1, `ser_out` is 1, and `rx_avail`, `rx_perr` and `rx_ovr` are 0.
- R3: A `wr_stb` pulse makes `tx_empty` low in the following cycle. If the shifter is idle, the byte moves into the shifter one cycle later. At that point `tx_empty` returns to 1 and `ser_out` goes low for the start bit.
- R4: A frame is sent in this order: start bit (0), data bits LSB first, the parity bit if enabled, then the stop bits (1). If a byte is waiting when the last stop cell ends, its start bit follows at once, with no idle cell in between.
- R5: A low level on `ser_in` that is high again when checked eight ticks after detection is rejected. No character is delivered.
- R6: With parity enabled, `rx_perr` is set when the received parity bit differs from the XOR of the 7 data bits, inverted when `par_odd` is 1. With parity disabled, `rx_perr` stays 0.
- R7: `rx_avail` rises when a character with a high stop sample completes. An `avail_clr` pulse clears `rx_avail`, `rx_perr` and `rx_ovr`.
- R8: If a character completes while `rx_avail` is still 1, the new character replaces `rd_data` and `rx_ovr` becomes 1.
- R9: The format inputs behave as follows. `par_en`=0 gives 8 data bits without parity, and `par_en`=1 gives 7 data bits plus parity. `par_odd`=0 selects even parity and `par_odd`=1 selects odd parity. `stop_one`=0 gives two stop bits and `stop_one`=1 gives one. The transmitted parity bit is the XOR of the data bits, XORed with `par_odd`.
- R10: In 7-bit mode, bit 7 of `rd_data` reads 0, whatever the parity cell carries.
- R11: A character whose stop sample is low is discarded: `rd_data` and the flags keep their previous values. The receiver then hunts for a new start bit.
- R12: A byte written while the shifter is busy keeps `tx_empty` low until the current frame's last stop cell ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| par_en | input | 1 | 1: 7 data bits plus parity; 0: 8 data bits |
| par_odd | input | 1 | 1: odd parity; 0: even parity |
| stop_one | input | 1 | 1: one stop bit; 0: two stop bits |
| wr_stb | input | 1 | Load `wr_data` into the transmit holding buffer |
| wr_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit holding buffer can accept a byte |
| ser_out | output | 1 | Serial transmit line, idles high |
| ser_in | input | 1 | Serial receive line, asynchronous |
| rd_data | output | 8 | Last received character |
| rx_avail | output | 1 | A received character is waiting |
| rx_perr | output | 1 | Parity error on the buffered character |
| rx_ovr | output | 1 | A character was overwritten before being read |
| avail_clr | input | 1 | Clear `rx_avail`, `rx_perr` and `rx_ovr` |

## Verification
The assertions are checked on every clock, next to the state machines. They cover these cycle-level rules:
- the empty flag drops after each write;
- an idle shifter takes a queued byte in the next cycle, and so does a finishing last stop cell;
- the flag updates on character completion and on the clear strobe;
- the parity flag stays low when parity is disabled;
- bit 7 is zero in 7-bit mode.

Only the directed scenarios can show the properties that depend on a whole frame:
- the bit order and cell lengths on the line;
- parity values under each format;
- the absence of a gap between back-to-back frames;
- rejection of a short start pulse;
- discarding of a character with a low stop bit.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_t;

endpackage

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop_one,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_empty,
    output logic              ser_out
);

    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DATA_W);

    tx_state_t         state, nxt;
    logic [DATA_W-1:0] hold_q;
    logic              hold_full;
    logic [DATA_W-1:0] shift_q;
    logic              par_q;
    logic [CW-1:0]     tcnt;
    logic [IW-1:0]     bidx;
    logic              sidx;

    logic              cell_end;
    logic              last_stop;
    logic              take;
    logic [IW-1:0]     last_idx;
    logic [DATA_W-1:0] dmask;

    assign cell_end  = tick && (tcnt == CW'(OVS - 1));
    assign last_stop = stop_one || sidx;
    assign last_idx  = par_en ? IW'(DATA_W - 2) : IW'(DATA_W - 1);
    assign dmask     = par_en ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
    assign take      = hold_full &&
                       ((state == TX_IDLE) ||
                        (state == TX_STOP && cell_end && last_stop));
    assign tx_empty  = !hold_full;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (hold_full) nxt = TX_START;
            TX_START: if (cell_end) nxt = TX_DATA;
            TX_DATA:  if (cell_end && bidx == last_idx)
                          nxt = par_en ? TX_PAR : TX_STOP;
            TX_PAR:   if (cell_end) nxt = TX_STOP;
            TX_STOP:  if (cell_end && last_stop)
                          nxt = hold_full ? TX_START : TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    // holding buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (wr_stb) begin
            hold_q    <= wr_data;
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    // shifter and cell timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            par_q   <= 1'b0;
            tcnt    <= '0;
            bidx    <= '0;
            sidx    <= 1'b0;
        end else begin
            if (take) begin
                shift_q <= hold_q;
                par_q   <= (^(hold_q & dmask)) ^ par_odd;
                tcnt    <= '0;
            end else if (tick) begin
                tcnt <= (tcnt == CW'(OVS - 1)) ? '0 : tcnt + 1'b1;
            end
            if (state == TX_START && cell_end) bidx <= '0;
            if (state == TX_DATA && cell_end) begin
                bidx    <= bidx + 1'b1;
                shift_q <= shift_q >> 1;
            end
            if (state != TX_STOP)  sidx <= 1'b0;
            else if (cell_end)     sidx <= 1'b1;
        end
    end

    // line output
    always_comb begin
        unique case (state)
            TX_IDLE:  ser_out = 1'b1;
            TX_START: ser_out = 1'b0;
            TX_DATA:  ser_out = shift_q[0];
            TX_PAR:   ser_out = par_q;
            TX_STOP:  ser_out = 1'b1;
            default:  ser_out = 1'b1;
        endcase
    end

    p_empty_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !tx_empty);

    p_idle_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && hold_full) |=> (state == TX_START && !ser_out));

    p_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_STOP && cell_end && last_stop && hold_full)
        |=> (state == TX_START));

    p_busy_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && state != TX_IDLE && !(state == TX_STOP && cell_end && last_stop))
        |=> !tx_empty);

endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              ser_in,
    input  logic              avail_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_avail,
    output logic              rx_perr,
    output logic              rx_ovr
);

    localparam int CW   = $clog2(OVS);
    localparam int IW   = $clog2(DATA_W);
    localparam int HALF = OVS / 2;

    rx_state_t         state, nxt;
    logic              s1, s2;
    logic [CW-1:0]     rcnt;
    logic [IW-1:0]     ridx;
    logic [DATA_W-1:0] sh;
    logic              acc;
    logic              perr_pend;

    logic              mid_start;
    logic              sample;
    logic              done;
    logic [IW-1:0]     last_idx;

    assign mid_start = tick && (rcnt == CW'(HALF - 1));
    assign sample    = tick && (rcnt == CW'(OVS - 1));
    assign last_idx  = par_en ? IW'(DATA_W - 2) : IW'(DATA_W - 1);
    assign done      = (state == RX_STOP) && sample && s2;

    // input synchroniser
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= ser_in;
            s2 <= s1;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            RX_HUNT:  if (tick && !s2) nxt = RX_START;
            RX_START: if (mid_start) nxt = s2 ? RX_HUNT : RX_DATA;
            RX_DATA:  if (sample && ridx == last_idx)
                          nxt = par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (sample) nxt = RX_STOP;
            RX_STOP:  if (sample) nxt = RX_HUNT;
            default:  nxt = RX_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_HUNT;
        else        state <= nxt;
    end

    // sampling datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt      <= '0;
            ridx      <= '0;
            sh        <= '0;
            acc       <= 1'b0;
            perr_pend <= 1'b0;
        end else begin
            unique case (state)
                RX_HUNT: rcnt <= '0;
                RX_START: begin
                    if (mid_start) begin
                        rcnt      <= '0;
                        ridx      <= '0;
                        sh        <= '0;
                        acc       <= 1'b0;
                        perr_pend <= 1'b0;
                    end else if (tick) begin
                        rcnt <= rcnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (sample) begin
                        rcnt     <= '0;
                        sh[ridx] <= s2;
                        acc      <= acc ^ s2;
                        ridx     <= ridx + 1'b1;
                    end else if (tick) begin
                        rcnt <= rcnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (sample) begin
                        rcnt      <= '0;
                        perr_pend <= s2 != (acc ^ par_odd);
                    end else if (tick) begin
                        rcnt <= rcnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (sample)    rcnt <= '0;
                    else if (tick) rcnt <= rcnt + 1'b1;
                end
                default: rcnt <= '0;
            endcase
        end
    end

    // receive buffer and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rx_avail <= 1'b0;
            rx_perr  <= 1'b0;
            rx_ovr   <= 1'b0;
        end else if (done) begin
            rd_data  <= sh;
            rx_avail <= 1'b1;
            rx_perr  <= par_en && perr_pend;
            rx_ovr   <= rx_avail && !avail_clr;
        end else if (avail_clr) begin
            rx_avail <= 1'b0;
            rx_perr  <= 1'b0;
            rx_ovr   <= 1'b0;
        end
    end

    p_avail_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_avail);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (avail_clr && !done) |=> (!rx_avail && !rx_perr && !rx_ovr));

    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_avail && !avail_clr) |=> rx_ovr);

    p_perr_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !par_en) |=> !rx_perr);

    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && par_en) |=> !rd_data[DATA_W-1]);

    p_frame_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STOP && sample && !s2 && !avail_clr) |=> $stable(rd_data) && $stable(rx_avail));

endmodule

// File: rtl/sio_xcvr.sv
module sio_xcvr #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop_one,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_empty,
    output logic              ser_out,
    input  logic              ser_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_avail,
    output logic              rx_perr,
    output logic              rx_ovr,
    input  logic              avail_clr
);

    sio_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .stop_one (stop_one),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .tx_empty (tx_empty),
        .ser_out  (ser_out)
    );

    sio_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .ser_in    (ser_in),
        .avail_clr (avail_clr),
        .rd_data   (rd_data),
        .rx_avail  (rx_avail),
        .rx_perr   (rx_perr),
        .rx_ovr    (rx_ovr)
    );

    p_reset_idle_r2: assert property (@(posedge clk)
        !rst_n |=> (tx_empty && ser_out && !rx_avail && !rx_perr && !rx_ovr));

endmodule

// File: tb/sio_xcvr_test.sv
module sio_xcvr_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       stop_one = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_empty;
    logic       ser_out;
    logic       ser_in = 1'b1;
    logic [7:0] rd_data;
    logic       rx_avail;
    logic       rx_perr;
    logic       rx_ovr;
    logic       avail_clr = 1'b0;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;
    logic [1:0] div = 2'd0;

    localparam int CELL = 64;  // 16 ticks of 4 clocks

    always #10 clk = ~clk;

    always @(posedge clk) begin
        div    <= div + 2'd1;
        tick16 <= (div == 2'd3);
    end

    sio_xcvr uut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .par_en(par_en), .par_odd(par_odd), .stop_one(stop_one),
        .wr_stb(wr_stb), .wr_data(wr_data), .tx_empty(tx_empty), .ser_out(ser_out),
        .ser_in(ser_in), .rd_data(rd_data), .rx_avail(rx_avail),
        .rx_perr(rx_perr), .rx_ovr(rx_ovr), .avail_clr(avail_clr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input bit pe, input bit odd, input bit one);
        @(negedge clk);
        par_en = pe; par_odd = odd; stop_one = one;
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic clear_rx();
        @(negedge clk); avail_clr = 1'b1;
        @(negedge clk); avail_clr = 1'b0;
    endtask

    // wait for a falling edge on ser_out, then move to the start cell centre
    task automatic wait_start(input string tag);
        int n = 0;
        while (ser_out !== 1'b0 && n < 5000) begin
            @(negedge clk); n++;
        end
        chk({tag, " start seen"}, int'(ser_out), 0);
        repeat (CELL/2) @(negedge clk);
    endtask

    // called at the start cell centre; checks a whole frame
    task automatic tx_frame(input string tag, input logic [7:0] d, input int nb,
                            input bit pe, input bit odd, input int nstop);
        logic p = odd;
        chk({tag, " R4 start bit"}, int'(ser_out), 0);
        for (int i = 0; i < nb; i++) begin
            repeat (CELL) @(negedge clk);
            chk({tag, " R1/R4 data bit"}, int'(ser_out), int'(d[i]));
            p = p ^ d[i];
        end
        if (pe) begin
            repeat (CELL) @(negedge clk);
            chk({tag, " R9 parity bit"}, int'(ser_out), int'(p));
        end
        for (int s = 0; s < nstop; s++) begin
            repeat (CELL) @(negedge clk);
            chk({tag, " R4 stop bit"}, int'(ser_out), 1);
        end
    endtask

    task automatic rx_send(input logic [7:0] d, input int nb, input bit pe,
                           input bit pbit, input bit stopv, input int stoplen);
        @(negedge clk);
        ser_in = 1'b0;
        repeat (CELL) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            ser_in = d[i];
            repeat (CELL) @(negedge clk);
        end
        if (pe) begin
            ser_in = pbit;
            repeat (CELL) @(negedge clk);
        end
        ser_in = stopv;
        repeat (stoplen) @(negedge clk);
        ser_in = 1'b1;
        repeat (2*CELL) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R2 tx_empty", int'(tx_empty), 1);
        chk("R2 ser_out", int'(ser_out), 1);
        chk("R2 rx_avail", int'(rx_avail), 0);
        chk("R2 rx_perr", int'(rx_perr), 0);
        chk("R2 rx_ovr", int'(rx_ovr), 0);
    endtask

    task automatic t_tx_load_8n2();
        cfg(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        wr_data = 8'hA5; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        chk("R3 empty low after write", int'(tx_empty), 0);
        @(negedge clk);
        chk("R3 empty back high", int'(tx_empty), 1);
        chk("R3 start bit begins", int'(ser_out), 0);
        repeat (CELL/2 - 1) @(negedge clk);
        tx_frame("8N2", 8'hA5, 8, 1'b0, 1'b0, 2);
        repeat (CELL) @(negedge clk);
        chk("R9 idle after two stops", int'(ser_out), 1);
    endtask

    task automatic t_tx_parity();
        cfg(1'b1, 1'b0, 1'b1);
        write_byte(8'h53);
        wait_start("7E1");
        tx_frame("7E1", 8'h53, 7, 1'b1, 1'b0, 1);
        repeat (3*CELL) @(negedge clk);
        cfg(1'b1, 1'b1, 1'b0);
        write_byte(8'h55);
        wait_start("7O2");
        tx_frame("7O2", 8'h55, 7, 1'b1, 1'b1, 2);
        repeat (3*CELL) @(negedge clk);
    endtask

    task automatic t_tx_b2b();
        cfg(1'b0, 1'b0, 1'b1);
        write_byte(8'h0F);
        repeat (4) @(negedge clk);
        write_byte(8'hF0);
        repeat (4) @(negedge clk);
        chk("R12 empty low while busy", int'(tx_empty), 0);
        wait_start("b2b first");
        tx_frame("b2b first", 8'h0F, 8, 1'b0, 1'b0, 1);
        chk("R12 still queued at stop", int'(tx_empty), 0);
        repeat (CELL) @(negedge clk);
        chk("R12 taken at frame end", int'(tx_empty), 1);
        tx_frame("R4 b2b no gap", 8'hF0, 8, 1'b0, 1'b0, 1);
        repeat (3*CELL) @(negedge clk);
    endtask

    task automatic t_rx_basic();
        cfg(1'b0, 1'b0, 1'b1);
        rx_send(8'h3C, 8, 1'b0, 1'b0, 1'b1, CELL);
        chk("R7 avail after char", int'(rx_avail), 1);
        chk("R9 8-bit data", int'(rd_data), 'h3C);
        chk("R6 perr low parity off", int'(rx_perr), 0);
        chk("R8 no overrun", int'(rx_ovr), 0);
        clear_rx();
        chk("R7 avail cleared", int'(rx_avail), 0);
    endtask

    task automatic t_rx_parity();
        cfg(1'b1, 1'b0, 1'b1);
        rx_send(8'h01, 7, 1'b1, 1'b1, 1'b1, CELL);
        chk("R10 7-bit data upper zero", int'(rd_data), 'h01);
        chk("R6 even parity ok", int'(rx_perr), 0);
        clear_rx();
        rx_send(8'h7F, 7, 1'b1, 1'b0, 1'b1, CELL);
        chk("R6 even parity wrong", int'(rx_perr), 1);
        chk("R10 upper zero", int'(rd_data), 'h7F);
        clear_rx();
        chk("R7 perr cleared", int'(rx_perr), 0);
        cfg(1'b1, 1'b1, 1'b1);
        rx_send(8'h7F, 7, 1'b1, 1'b0, 1'b1, CELL);
        chk("R6 odd parity ok", int'(rx_perr), 0);
        clear_rx();
    endtask

    task automatic t_rx_overrun();
        cfg(1'b0, 1'b0, 1'b1);
        rx_send(8'h11, 8, 1'b0, 1'b0, 1'b1, CELL);
        rx_send(8'h22, 8, 1'b0, 1'b0, 1'b1, CELL);
        chk("R8 overrun set", int'(rx_ovr), 1);
        chk("R8 newest data", int'(rd_data), 'h22);
        clear_rx();
        chk("R7 overrun cleared", int'(rx_ovr), 0);
    endtask

    task automatic t_rx_noise();
        cfg(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        ser_in = 1'b0;
        repeat (16) @(negedge clk);
        ser_in = 1'b1;
        repeat (12*CELL) @(negedge clk);
        chk("R5 short pulse rejected", int'(rx_avail), 0);
        rx_send(8'h5A, 8, 1'b0, 1'b0, 1'b1, CELL);
        chk("R5 receive after noise", int'(rd_data), 'h5A);
        clear_rx();
    endtask

    task automatic t_rx_framing();
        rx_send(8'h99, 8, 1'b0, 1'b0, 1'b0, 48);
        repeat (CELL) @(negedge clk);
        chk("R11 bad stop discarded", int'(rx_avail), 0);
        chk("R11 data kept", int'(rd_data), 'h5A);
        rx_send(8'h66, 8, 1'b0, 1'b0, 1'b1, CELL);
        chk("R11 hunt resumes", int'(rd_data), 'h66);
        chk("R11 avail after resume", int'(rx_avail), 1);
        clear_rx();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_load_8n2();
        t_tx_parity();
        t_tx_b2b();
        t_rx_basic();
        t_rx_parity();
        t_rx_overrun();
        t_rx_noise();
        t_rx_framing();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=complete");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule